// File: doc/BRIEF.md
# Cache Event Counter Unit

This block watches single-cycle event strobes coming out of a level-2 cache pipeline and counts them in two independent counters. Each counter selects one event from a fixed list of fifteen sources and picks its own interrupt policy: no interrupt, an interrupt on every count, or an interrupt only when the counter wraps. Both counters share one interrupt status bit. Eight error lines from the cache (parity, RAM access, slave and decode errors) sit beside it in the same status word.

Software reaches the unit through a simple word-wide read/write bus. There is one control word, one configuration word and one value word per counter, and four interrupt words: mask, masked status, raw status and write-one-to-clear. The unit drives a level interrupt that stays high while any unmasked status bit is set.

Top module: `l2_evt_mon`

## Requirements
- R1: After reset both counters read 0, the control word reads 0, raw and masked status read 0, the mask reads 0x1FF and `irq_o` is low.
- R2: A counter adds one on each cycle in which control bit 0 (global enable) is set, its source field is nonzero, and the strobe `evt_i[src-1]` is high. When the enable is clear, or the source is 0, it holds its value.
- R3: A configuration word holds the event source in bits 5:2 and the interrupt type in bits 1:0, and reads back as written. Counter 0 is configured at byte offset 0x208 and counter 1 at 0x204. Its value is read at 0x210 for counter 0 and at 0x20C for counter 1. The control word is at 0x200.
- R4: Writing control bit 1 or bit 2 clears counter 0 or counter 1 respectively and leaves the other counter alone. Both bits read back as 0.
- R5: A counter at its all-ones value wraps to 0 on its next count. The width is the parameter `CNT_W`, 32 by default.
- R6: Raw status bit 0 is set by a counter whose type is 1 on each of its counts, and by a counter whose type is 2 only on its wrapping count. Type 0 never sets it.
- R7: A high `err_i[k]` sets raw status bit k+1, and the bit stays set. Raw status (0x21C) bits 31:9 read 0.
- R8: Writing the clear word (0x220) clears each raw status bit written as 1. A new event in the same cycle keeps its bit set.
- R9: Masked status (0x218) equals raw status AND mask (0x214). Only mask bits 8:0 are writable. `irq_o` is high exactly when masked status is nonzero.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.
- R11: A value read in the same cycle as a count returns the value before the count. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 12 | Byte address; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational for a read access, 0 otherwise |
| evt_i | input | 15 | Event strobes; bit s-1 is source s |
| err_i | input | 8 | Error strobes feeding raw status bits 8:1 |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things. A counter moves only by one step or to zero. It holds when disabled. A counter-clear request empties the counter on the next cycle. A raw status bit falls only after a clear write to that bit. They also check that error strobes are captured and that the interrupt is low whenever no status bit is both raw and unmasked. Some behaviour only the bench scenarios can show. This covers the source encoding, the per-type interrupt policy up to an actual wrap, the priority of a new event over a simultaneous clear, and the pre-count value returned by a read in the counting cycle. It also covers read-back of the register words and the silence of unmapped offsets.

// File: rtl/l2_evt_pkg.sv
package l2_evt_pkg;
  localparam int NUM_SRC = 15;
  localparam int NUM_ERR = 8;
  localparam int NUM_CTR = 2;
  localparam int STAT_W  = NUM_ERR + 1;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_EACH = 2'd1,
    IRQ_WRAP = 2'd2
  } irq_mode_e;

  typedef struct packed {
    logic [3:0] src;
    logic [1:0] mode;
  } ctr_cfg_t;

  // word offsets (byte offset >> 2)
  localparam logic [9:0] W_CTRL  = 10'h080;  // 0x200
  localparam logic [9:0] W_CFG1  = 10'h081;  // 0x204
  localparam logic [9:0] W_CFG0  = 10'h082;  // 0x208
  localparam logic [9:0] W_VAL1  = 10'h083;  // 0x20C
  localparam logic [9:0] W_VAL0  = 10'h084;  // 0x210
  localparam logic [9:0] W_MASK  = 10'h085;  // 0x214
  localparam logic [9:0] W_MSTAT = 10'h086;  // 0x218
  localparam logic [9:0] W_RAW   = 10'h087;  // 0x21C
  localparam logic [9:0] W_CLR   = 10'h088;  // 0x220
endpackage

// File: rtl/l2_evt_counter.sv
module l2_evt_counter
  import l2_evt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             zero_i,
  input  ctr_cfg_t         cfg_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [NUM_SRC:0] evt_ext;
  logic             sel, inc, wrap;
  logic [CNT_W-1:0] cnt_q;

  // slot 0 is the disabled source
  assign evt_ext = {evt_i, 1'b0};
  assign sel     = evt_ext[cfg_i.src];
  assign inc     = en_i & sel;
  assign wrap    = inc & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (zero_i) cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (cfg_i.mode)
      IRQ_EACH: hit_o = inc;
      IRQ_WRAP: hit_o = wrap;
      default:  hit_o = 1'b0;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/l2_evt_irq.sv
module l2_evt_irq
  import l2_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '1;
    end else begin
      raw_q <= (raw_q & ~clr_i) | set_i;  // set beats clear
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/l2_evt_mon.sv
module l2_evt_mon
  import l2_evt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [14:0] evt_i,
  input  logic [7:0]  err_i,
  output logic        irq_o
);
  logic [9:0]        waddr;
  logic              wr, rd;
  logic              en_q;
  ctr_cfg_t          cfg_q [NUM_CTR];
  logic [CNT_W-1:0]  cnt_val [NUM_CTR];
  logic [NUM_CTR-1:0] hit_v, zero_v;
  logic [STAT_W-1:0] set_v, clr_v, raw_v, mask_v, masked_v;
  logic [31:0]       rmux;
  logic              unused_bits;

  assign waddr = addr_i[11:2];
  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:9]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (wr && waddr == W_CTRL) en_q <= wdata_i[0];
  end

  // counter i clear request on control bit i+1, self-clearing
  assign zero_v[0] = wr && waddr == W_CTRL && wdata_i[1];
  assign zero_v[1] = wr && waddr == W_CTRL && wdata_i[2];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [9:0] CFG_OFF = (i == 0) ? W_CFG0 : W_CFG1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (wr && waddr == CFG_OFF) cfg_q[i] <= wdata_i[5:0];
    end

    l2_evt_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q),
      .zero_i (zero_v[i]),
      .cfg_i  (cfg_q[i]),
      .evt_i  (evt_i),
      .cnt_o  (cnt_val[i]),
      .hit_o  (hit_v[i])
    );
  end

  assign set_v = {err_i, |hit_v};
  assign clr_v = (wr && waddr == W_CLR) ? wdata_i[STAT_W-1:0] : '0;

  l2_evt_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_v),
    .clr_i     (clr_v),
    .mask_we_i (wr && waddr == W_MASK),
    .mask_i    (wdata_i[STAT_W-1:0]),
    .raw_o     (raw_v),
    .mask_o    (mask_v),
    .masked_o  (masked_v),
    .irq_o     (irq_o)
  );

  always_comb begin
    rmux = '0;
    case (waddr)
      W_CTRL:  rmux = {31'd0, en_q};
      W_CFG0:  rmux = {26'd0, cfg_q[0]};
      W_CFG1:  rmux = {26'd0, cfg_q[1]};
      W_VAL0:  rmux = 32'(cnt_val[0]);
      W_VAL1:  rmux = 32'(cnt_val[1]);
      W_MASK:  rmux = 32'(mask_v);
      W_MSTAT: rmux = 32'(masked_v);
      W_RAW:   rmux = 32'(raw_v);
      default: rmux = '0;
    endcase
  end

  assign rdata_o = rd ? rmux : '0;
endmodule

module l2_evt_mon_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic [1:0]       zero_v,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [8:0]       raw_v,
  input logic [8:0]       mask_v,
  input logic [8:0]       clr_v,
  input logic [7:0]       err_i,
  input logic             irq_o
);
  // R2
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !zero_v[0]) |=> $stable(cnt0));
  // R4
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_v[1] |=> (cnt1 == '0));
  // R5
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0 != $past(cnt0)) |-> ((cnt0 == CNT_W'($past(cnt0) + 1'b1)) || (cnt0 == '0)));
  // R8
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(raw_v[0]) |-> $past(clr_v[0]));
  // R7
  err_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != 0) |=> ((raw_v[8:1] & $past(err_i)) == $past(err_i)));
  // R9
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_v & mask_v) == 0) |-> !irq_o);
endmodule

bind l2_evt_mon l2_evt_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_q   (en_q),
  .zero_v (zero_v),
  .cnt0   (cnt_val[0]),
  .cnt1   (cnt_val[1]),
  .raw_v  (raw_v),
  .mask_v (mask_v),
  .clr_v  (clr_v),
  .err_i  (err_i),
  .irq_o  (irq_o)
);

// File: tb/sim_l2_evt_mon.sv
module sim_l2_evt_mon;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] evt = '0;
  logic [7:0]  err = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  l2_evt_mon #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .err_i(err), .irq_o(irq)
  );

  localparam logic [11:0] A_CTRL = 12'h200, A_CFG1 = 12'h204, A_CFG0 = 12'h208,
    A_VAL1 = 12'h20C, A_VAL0 = 12'h210, A_MASK = 12'h214, A_MST = 12'h218,
    A_RAW = 12'h21C, A_CLR = 12'h220;

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, A_CTRL, 32'h0,        32'h0},    // R1
    '{1'b0, A_MASK, 32'h0,        32'h1FF},  // R1
    '{1'b0, A_RAW,  32'h0,        32'h0},    // R1
    '{1'b0, A_VAL0, 32'h0,        32'h0},    // R1
    '{1'b0, A_VAL1, 32'h0,        32'h0},    // R1
    '{1'b1, A_CFG0, 32'h9,        32'h0},
    '{1'b0, A_CFG0, 32'h0,        32'h9},    // R3
    '{1'b1, A_CFG1, 32'h16,       32'h0},
    '{1'b0, A_CFG1, 32'h0,        32'h16},   // R3
    '{1'b0, 12'h300, 32'h0,       32'h0},    // R10
    '{1'b1, 12'h300, 32'hFFFFFFFF, 32'h0},
    '{1'b0, A_MASK, 32'h0,        32'h1FF},  // R10
    '{1'b1, A_MASK, 32'hFFFFFFFF, 32'h0},
    '{1'b0, A_MASK, 32'h0,        32'h1FF}   // R9 upper bits not kept
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 check(tag, rdata, exp);
    req = 0;
  endtask

  task automatic pulse(input logic [14:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = m;
    end
    @(negedge clk); evt = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].w) wr(TBL[i].a, TBL[i].d);
      else rd(TBL[i].a, TBL[i].e, "R1/R3/R9/R10 table");
    end

    // R2: disabled globally -> no count
    pulse(15'h0002, 3);
    rd(A_VAL0, 0, "R2 disabled");
    wr(A_CTRL, 32'h1);
    pulse(15'h0002, 3);
    pulse(15'h0001, 1);
    rd(A_VAL0, 3, "R2 counted");

    // R11: read in counting cycle
    @(negedge clk); evt = 15'h0002; req = 1; we = 0; addr = A_VAL0;
    #1 check("R11 pre-count", rdata, 3);
    @(negedge clk); evt = '0; req = 0;
    rd(A_VAL0, 4, "R11 post-count");

    // R6 type 1, R9 irq
    rd(A_RAW, 1, "R6 each");
    check("R9 irq high", {31'd0, irq}, 1);
    wr(A_CLR, 32'h1);
    rd(A_RAW, 0, "R8 clear");
    check("R9 irq low", {31'd0, irq}, 0);

    // R8: event beats clear
    @(negedge clk); req = 1; we = 1; addr = A_CLR; wdata = 1; evt = 15'h0002;
    @(negedge clk); req = 0; we = 0; evt = '0;
    rd(A_RAW, 1, "R8 event wins");
    rd(A_VAL0, 5, "R2 count");
    wr(A_CLR, 32'h1);

    // counter 1: src 5, wrap mode
    pulse(15'h0010, 2);
    rd(A_VAL1, 2, "R2 ctr1");
    rd(A_RAW, 0, "R6 wrap no irq");

    // R4
    wr(A_CTRL, 32'h3);
    rd(A_VAL0, 0, "R4 ctr0 cleared");
    rd(A_VAL1, 2, "R4 ctr1 kept");
    rd(A_CTRL, 1, "R4 self-clear");

    // R5 wrap
    pulse(15'h0010, 253);
    rd(A_VAL1, 255, "R5 at max");
    rd(A_RAW, 0, "R6 no wrap yet");
    pulse(15'h0010, 1);
    rd(A_VAL1, 0, "R5 wrapped");
    rd(A_RAW, 1, "R6 wrap irq");
    wr(A_CLR, 32'h1);

    // R6 type 0
    wr(A_CFG0, 32'h8);
    pulse(15'h0002, 1);
    rd(A_VAL0, 1, "R2 type0 counts");
    rd(A_RAW, 0, "R6 type0 silent");

    // R2 source 0
    wr(A_CFG0, 32'h1);
    pulse(15'h7FFF, 2);
    rd(A_VAL0, 1, "R2 src0 holds");
    rd(A_RAW, 0, "R2 src0 no irq");

    // R7 errors, R9 masking
    @(negedge clk); err = 8'h08;
    @(negedge clk); err = '0;
    rd(A_RAW, 32'h10, "R7 err bit");
    rd(A_RAW, 32'h10, "R7 sticky");
    wr(A_MASK, 0);
    rd(A_MST, 0, "R9 masked off");
    check("R9 irq masked", {31'd0, irq}, 0);
    wr(A_MASK, 32'h10);
    rd(A_MST, 32'h10, "R9 masked on");
    check("R9 irq on", {31'd0, irq}, 1);
    wr(A_CLR, 32'h1FF);
    rd(A_RAW, 0, "R8 clear all");

    done = 1;
    finish_run();
  end
endmodule